// File: doc/BRIEF.md
# Parallel Word-Wide Tausworthe Pseudo-Random Generator

This block produces pseudo-random words from a two-tap linear recurrence over a P-bit shift register. In each serial step, the register moves up by one position. The bit that enters at position 1 is the exclusive-or of the bits at positions Q and P, with positions counted from 1. A bit-serial engine would need L clocks before an L-bit output field held entirely new bits. This block instead chains L copies of the one-step recurrence in combinational logic, so every enabled clock delivers a complete fresh L-bit word.

Software or a neighbouring block first loads a P-bit seed, then holds `step_en` high for as many words as it needs. The word is a fixed field of the state register: state bits OFS through OFS+L-1, with word bit 0 taken from state bit OFS. The sequence depends only on the seed, so reloading a seed replays the same words. The all-zero state is a fixed point of the recurrence. To avoid it, a zero seed, and reset, put the value 1 into the register.

Top module: `tw_wordgen`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes 1 (only state bit 0 set) and `word_valid` becomes 0. With the default OFS of 0, `rnd_word` then reads 1.
- R2: One serial step maps state s to {s[P-2:0], s[Q-1] ^ s[P-1]}. Vector bit 0 is position 1, and with the defaults the taps are bits 0 and 62.
- R3: A clock edge with `step_en` high and `seed_load` low replaces the state with the result of exactly L serial steps applied to the previous state.
- R4: `rnd_word` equals state bits [OFS+L-1:OFS], and word bit 0 is state bit OFS.
- R5: A clock edge with `seed_load` high loads `seed_in` (when non-zero) into the state and clears `word_valid`. This holds whatever `step_en` is.
- R6: An all-zero `seed_in` loads the value 1 instead.
- R7: `word_valid` rises on the first advance after reset or a seed load. It then stays high until the next reset or load.
- R8: With `seed_load` and `step_en` both low, `rnd_word` and `word_valid` keep their values.
- R9: Loading the same seed again and issuing the same advances reproduces the same word sequence.
- R10: The state never becomes all zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_in` into the state |
| seed_in | input | P | Seed value |
| step_en | input | 1 | Advance the state by L serial steps |
| rnd_word | output | L | Current random word |
| word_valid | output | 1 | Word has been produced by at least one advance |

## Verification
The hardest situation to reach from the ports is the register close to the degenerate zero state. Examples are a seed whose only set bit is at the top tap, and a zero seed that must be replaced. Random seeds almost never produce either. The bench therefore loads both seeds directly, and also a seed loaded together with an advance. It then lets a bit-serial model, stepped L times per word, follow them. A recorded run is replayed from the same seed to show that the sequence is repeatable.

// File: rtl/tw_pkg.sv
package tw_pkg;
    // Operation chosen for the next state register update.
    typedef enum logic [1:0] {
        TW_HOLD = 2'd0,
        TW_LOAD = 2'd1,
        TW_STEP = 2'd2
    } tw_op_e;
endpackage

// File: rtl/tw_seed_guard.sv
module tw_seed_guard #(
    parameter int P = 63
) (
    input  logic [P-1:0] raw_seed,
    output logic [P-1:0] safe_seed
);
    localparam logic [P-1:0] FILL = P'(1);

    always_comb begin
        safe_seed = (raw_seed == '0) ? FILL : raw_seed;
    end
endmodule

// File: rtl/tw_step_chain.sv
module tw_step_chain #(
    parameter int P = 63,
    parameter int Q = 1,
    parameter int L = 32
) (
    input  logic [P-1:0] cur_state,
    output logic [P-1:0] nxt_state
);
    logic [P-1:0] stage [0:L];

    assign stage[0] = cur_state;

    for (genvar k = 0; k < L; k++) begin : g_step
        // One serial recurrence step: shift up, feed back tap Q xor tap P.
        assign stage[k+1] = {stage[k][P-2:0], stage[k][Q-1] ^ stage[k][P-1]};
    end

    assign nxt_state = stage[L];
endmodule

// File: rtl/tw_wordgen.sv
module tw_wordgen #(
    parameter int P   = 63,
    parameter int Q   = 1,
    parameter int L   = 32,
    parameter int OFS = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_load,
    input  logic [P-1:0] seed_in,
    input  logic         step_en,
    output logic [L-1:0] rnd_word,
    output logic         word_valid
);
    import tw_pkg::*;

    localparam logic [P-1:0] FILL = P'(1);

    if (!(Q > 0 && Q < P)) begin : g_bad_tap
        $error("tw_wordgen: tap Q must satisfy 0 < Q < P");
    end
    if (!(L > 0 && OFS >= 0 && OFS + L <= P)) begin : g_bad_window
        $error("tw_wordgen: output window must fit inside the state");
    end

    typedef struct packed {
        logic [P-1:0] state;
        logic         valid;
    } gen_t;

    gen_t         gen_d, gen_q;
    tw_op_e       op;
    logic [P-1:0] stepped;
    logic [P-1:0] clean_seed;

    tw_step_chain #(.P(P), .Q(Q), .L(L)) u_chain (
        .cur_state (gen_q.state),
        .nxt_state (stepped)
    );

    tw_seed_guard #(.P(P)) u_guard (
        .raw_seed  (seed_in),
        .safe_seed (clean_seed)
    );

    always_comb begin
        if (seed_load)    op = TW_LOAD;
        else if (step_en) op = TW_STEP;
        else              op = TW_HOLD;

        gen_d = gen_q;
        unique case (op)
            TW_LOAD: begin
                gen_d.state = clean_seed;
                gen_d.valid = 1'b0;
            end
            TW_STEP: begin
                gen_d.state = stepped;
                gen_d.valid = 1'b1;
            end
            default: gen_d = gen_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q.state <= FILL;
            gen_q.valid <= 1'b0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign rnd_word   = gen_q.state[OFS +: L];
    assign word_valid = gen_q.valid;

    // R5
    load_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !word_valid);

    // R5
    load_takes_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_in != '0) |=> gen_q.state == $past(seed_in));

    // R6
    zero_seed_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_in == '0) |=> gen_q.state == FILL);

    // R7
    advance_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load) |=> word_valid);

    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !seed_load) |=> ($stable(rnd_word) && $stable(word_valid)));

    // R10
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        gen_q.state != '0);
endmodule

// File: tb/tw_wordgen_test.sv
module tw_wordgen_test;
    localparam int P = 63;
    localparam int Q = 1;
    localparam int L = 32;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_load = 1'b0;
    logic [P-1:0] seed_in = '0;
    logic         step_en = 1'b0;
    logic [L-1:0] rnd_word;
    logic         word_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [P-1:0] m_state = P'(1);
    logic         m_valid = 1'b0;
    logic [L-1:0] rec [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_wordgen #(.P(P), .Q(Q), .L(L), .OFS(0)) uut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_in(seed_in),
        .step_en(step_en), .rnd_word(rnd_word), .word_valid(word_valid)
    );

    function automatic logic [P-1:0] ser_step(input logic [P-1:0] s);
        return {s[P-2:0], s[Q-1] ^ s[P-1]};
    endfunction

    function automatic logic [P-1:0] word_step(input logic [P-1:0] s);
        logic [P-1:0] t = s;
        for (int i = 0; i < L; i++) t = ser_step(t);
        return t;
    endfunction

    function automatic logic [P-1:0] rnd_seed();
        logic [63:0] w = {$urandom(), $urandom()};
        return w[P-1:0];
    endfunction

    task automatic check(input string req);
        n_chk++;
        if (rnd_word !== m_state[L-1:0] || word_valid !== m_valid) begin
            n_bad++;
            $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
                     req, rnd_word, word_valid, m_state[L-1:0], m_valid);
        end
    endtask

    // Drive at negedge, update model at the edge, compare at next negedge.
    task automatic cycle(input logic ld, input logic [P-1:0] sd,
                         input logic adv, input string req);
        seed_load = ld; seed_in = sd; step_en = adv;
        @(posedge clk);
        if (ld) begin
            m_state = (sd == '0) ? P'(1) : sd;
            m_valid = 1'b0;
        end else if (adv) begin
            m_state = word_step(m_state);
            m_valid = 1'b1;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [P-1:0] s1;
        void'($urandom(32'd4711));
        @(negedge clk);
        @(negedge clk);
        // R1 reset state, R4 window of value 1
        check("R1");
        rst = 1'b0;
        cycle(1'b0, '0, 1'b0, "R8");

        // R5 seed load, R4 window
        s1 = rnd_seed();
        cycle(1'b1, s1, 1'b0, "R5");
        // R3 R7 advances, recorded for R9
        for (int i = 0; i < 16; i++) begin
            cycle(1'b0, '0, 1'b1, "R3");
            rec[i] = rnd_word;
        end
        cycle(1'b0, '0, 1'b0, "R8");
        // R9 replay
        cycle(1'b1, s1, 1'b0, "R9");
        for (int i = 0; i < 16; i++) begin
            cycle(1'b0, '0, 1'b1, "R9");
            n_chk++;
            if (rnd_word !== rec[i]) begin
                n_bad++;
                $display("FAIL R9: word=%h expected=%h", rnd_word, rec[i]);
            end
        end

        // R5 load wins over advance
        cycle(1'b1, rnd_seed(), 1'b1, "R5");
        // R6 zero seed, then R10 advances from fill
        cycle(1'b1, '0, 1'b0, "R6");
        cycle(1'b0, '0, 1'b1, "R7");
        cycle(1'b0, '0, 1'b1, "R10");
        // R2 only top tap set
        cycle(1'b1, {1'b1, {(P-1){1'b0}}}, 1'b0, "R2");
        cycle(1'b0, '0, 1'b1, "R2");
        cycle(1'b0, '0, 1'b1, "R2");
        // R2 only low tap set
        cycle(1'b1, P'(1) << (Q-1), 1'b0, "R2");
        cycle(1'b0, '0, 1'b1, "R2");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom();
            cycle(r[4:0] == 5'd0, rnd_seed(), r[8:7] != 2'b00, "R3");
        end

        // R1 reset mid-run
        rst = 1'b1;
        @(posedge clk);
        m_state = P'(1); m_valid = 1'b0;
        @(negedge clk);
        check("R1");
        rst = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule